// File: doc/BRIEF.md
# Packed Shader Uniform Loader

This block sits behind a register-write port and builds four-component shader uniform vectors. Each vector has 24-bit float components and is kept in a 96-entry uniform store. Software first writes a setup register with a target slot and an input format. It then streams 32-bit words to any one of eight equivalent data selects. In float32 format each word is one IEEE single that the block narrows to float24, so four words make one vector. In packed format the four 24-bit components come already packed into three 32-bit words. The component order is reversed on the way in, so the first word supplied feeds the highest component (w).

When a vector is complete it is written to the current slot, and the slot number then moves up by one. A stream of vectors therefore fills consecutive entries with no further setup writes. A completed vector aimed past the last entry is thrown away, a one-cycle error pulse is raised, and the slot number stays where it is. The block also holds a 16-bit register of boolean uniforms and four 32-bit registers of integer uniforms, each made of four byte-wide components. A combinational read port exposes any entry of the store for checking.

Top module: `uniform_pack_loader`

## Requirements
- R1: A vector completes on the 4th data write in float32 format and on the 3rd in packed format; the partial-word count then returns to zero, and no entry or slot number changes before completion.
- R2: In float32 format, data word k (k = 0..3 in arrival order) becomes component 3-k, so word 0 lands in w. A vector is read as {w,z,y,x}, with x at bits [23:0], y at [47:24], z at [71:48] and w at [95:72].
- R3: In packed format, with words a, b, c in arrival order: w = a[31:8], z = {a[7:0], b[31:16]}, y = {b[15:0], c[31:24]}, x = c[23:0].
- R4: float24 is {sign, 7-bit exponent biased by 63, 16-bit mantissa}. Conversion from float32 with exponent e works as follows. If e <= 64 the result is a signed zero. If e >= 192 the result is the sign with exponent 0x7F and a zero mantissa. Otherwise the exponent is e-64 and the mantissa is float32 bits [22:7].
- R5: After each vector is stored, the slot number shown on cur_index goes up by one.
- R6: A vector completed while the slot number is 96 or more is not stored. drop_err is high for exactly the cycle after that last write, and the slot number does not change.
- R7: A write to select 0x00 loads the slot number from bits [6:0] and the format from bit 31 (1 = float32, 0 = packed). It also discards any partial vector.
- R8: Selects 0x08 to 0x0F are equivalent data inputs. Writes to unmapped selects (0x02, 0x03, 0x10 to 0x1F) change nothing.
- R9: A write to select 0x01 sets boolean uniform i from bit i of the data, for i = 0..15.
- R10: A write to select 0x04+n (n = 0..3) loads integer uniform n, seen at int_uni[32n+31:32n], with component x in bits [7:0] and w in bits [31:24].
- R11: After reset, the slot number, format, error flag, boolean and integer uniforms and every store entry are zero.
- R12: The read port returns the addressed entry for indices 0..95 and zero for any larger index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register select |
| wr_data | input | 32 | Write data |
| rd_idx | input | 7 | Store read index |
| rd_vec | output | 96 | Store entry {w,z,y,x} |
| cur_index | output | 7 | Current slot number |
| f32_mode | output | 1 | 1 = float32 input format |
| drop_err | output | 1 | Pulse: completed vector dropped |
| bool_uni | output | 16 | Boolean uniforms |
| int_uni | output | 128 | Four integer uniform registers |

## Verification
A wrong partial-word count shows up as a vector landing one write early or late. This is visible on cur_index and the read port in the same cycle the vector should complete, and it also misaligns every later vector until the next setup write. Faults in the component order or in the packed field split show up on the read port as soon as the vector is stored. A faulty bounds test shows up either as an entry overwritten at slot 95 or as a missing drop_err pulse one cycle after the final word. The bench mixes seeded random writes across all selects with directed runs at the exponent thresholds, the last slot, setup writes in mid-vector and unmapped selects, and it compares every output after each write.

// File: rtl/uniform_pkg.sv
package uniform_pkg;
  localparam int WORD_W    = 32;
  localparam int F24_EXP_W = 7;
  localparam int F24_MAN_W = 16;
  localparam int F24_W     = 1 + F24_EXP_W + F24_MAN_W;
  localparam int NCOMP     = 4;
  localparam int VEC_W     = NCOMP * F24_W;
  localparam int SEL_W     = 5;
  localparam int ALIAS_N   = 8;
  localparam int NUM_INT   = 4;
  localparam int BOOL_W    = 16;
  localparam int MODE_BIT  = 31;

  localparam logic [SEL_W-1:0] SEL_CFG  = 5'h00;
  localparam logic [SEL_W-1:0] SEL_BOOL = 5'h01;
  localparam logic [SEL_W-1:0] SEL_INT  = 5'h04;
  localparam logic [SEL_W-1:0] SEL_DATA = 5'h08;

  typedef struct packed {
    logic cfg;
    logic bools;
    logic ints;
    logic data;
  } wr_dec_t;
endpackage

// File: rtl/f24_from_f32.sv
module f24_from_f32 #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 16
) (
  input  logic [8+MAN_W:0]     f32_hi_i,
  output logic [EXP_W+MAN_W:0] f24_o
);
  localparam int BIAS_OUT = (1 << (EXP_W - 1)) - 1;
  localparam int SHIFT    = 127 - BIAS_OUT;
  localparam int EXP_MAX  = (1 << EXP_W) - 1;
  localparam logic [7:0] SHIFT_L = 8'(SHIFT);
  localparam logic [8:0] EMAX_L  = 9'(EXP_MAX);

  logic             sgn;
  logic [7:0]       e_in;
  logic [MAN_W-1:0] m_in;
  logic [8:0]       e_diff;

  always_comb begin
    sgn    = f32_hi_i[8+MAN_W];
    e_in   = f32_hi_i[7+MAN_W:MAN_W];
    m_in   = f32_hi_i[MAN_W-1:0];
    e_diff = {1'b0, e_in} - {1'b0, SHIFT_L};
    if (e_in <= SHIFT_L) begin
      f24_o = {sgn, {(EXP_W+MAN_W){1'b0}}};
    end else if (e_diff > EMAX_L) begin
      f24_o = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else begin
      f24_o = {sgn, e_diff[EXP_W-1:0], m_in};
    end
  end
endmodule

// File: rtl/uniform_assembler.sv
module uniform_assembler
  import uniform_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              clear,
  input  logic              mode_f32,
  input  logic [WORD_W-1:0] wdata,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_o
);
  localparam int NHOLD = NCOMP - 1;
  localparam logic [1:0] LAST_F32 = 2'(NCOMP - 1);
  localparam logic [1:0] LAST_PK  = 2'(NCOMP - 2);
  localparam int HI_W = 9 + F24_MAN_W;

  logic [1:0]        cnt_q, cnt_d;
  logic [WORD_W-1:0] hold_q [NHOLD];
  logic [WORD_W-1:0] src    [NCOMP];
  logic [F24_W-1:0]  cvt    [NCOMP];
  logic [VEC_W-1:0]  vec_f32, vec_pk;
  logic [1:0]        last;
  logic              hold_en;

  assign last      = mode_f32 ? LAST_F32 : LAST_PK;
  assign vec_valid = data_we && (cnt_q == last);
  assign hold_en   = data_we && !vec_valid && !clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)          cnt_d = '0;
    else if (vec_valid) cnt_d = '0;
    else if (data_we)   cnt_d = cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  genvar h;
  generate
    for (h = 0; h < NHOLD; h++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              hold_q[h] <= '0;
        else if (hold_en && (cnt_q == 2'(h)))    hold_q[h] <= wdata;
      end
    end
  endgenerate

  genvar k;
  generate
    for (k = 0; k < NCOMP; k++) begin : g_cvt
      if (k < NHOLD) begin : g_held
        assign src[k] = hold_q[k];
      end else begin : g_live
        assign src[k] = wdata;
      end
      f24_from_f32 #(.EXP_W(F24_EXP_W), .MAN_W(F24_MAN_W)) u_cvt (
        .f32_hi_i (src[k][WORD_W-1 -: HI_W]),
        .f24_o    (cvt[k])
      );
      assign vec_f32[(NCOMP-1-k)*F24_W +: F24_W] = cvt[k];
    end
  endgenerate

  assign vec_pk = {hold_q[0], hold_q[1], wdata};
  assign vec_o  = mode_f32 ? vec_f32 : vec_pk;

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_f32 |-> (cnt_q <= LAST_PK));
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> (cnt_q == 2'd0));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == 2'd0));
endmodule

// File: rtl/uniform_store.sv
module uniform_store
  import uniform_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_mode,
  input  logic             vec_valid,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VEC_W-1:0] rd_vec,
  output logic [IDX_W-1:0] idx_o,
  output logic             mode_o,
  output logic             drop_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             mode_q, mode_d;
  logic             drop_q, drop_d;
  logic             in_range, store;
  logic [VEC_W-1:0] mem_q [DEPTH];

  assign in_range = (idx_q <= LAST_IDX);
  assign store    = vec_valid && in_range;

  always_comb begin
    idx_d  = idx_q;
    mode_d = mode_q;
    drop_d = vec_valid && !in_range;
    if (cfg_we) begin
      idx_d  = cfg_idx;
      mode_d = cfg_mode;
    end else if (store) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      mode_q <= mode_d;
      drop_q <= drop_d;
    end
  end

  genvar e;
  generate
    for (e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             mem_q[e] <= '0;
        else if (store && (idx_q == IDX_W'(e))) mem_q[e] <= vec_i;
      end
    end
  endgenerate

  assign rd_vec = (rd_idx <= LAST_IDX) ? mem_q[rd_idx] : '0;
  assign idx_o  = idx_q;
  assign mode_o = mode_q;
  assign drop_o = drop_q;

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !cfg_we && in_range) |=> (idx_q == $past(idx_q) + 1'b1));
  p_drop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !cfg_we && !in_range) |=> (drop_o && $stable(idx_q)));
  p_drop_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |=> !drop_o);
  p_cfg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (idx_q == $past(cfg_idx) && mode_q == $past(cfg_mode)));
endmodule

// File: rtl/uniform_pack_loader.sv
module uniform_pack_loader
  import uniform_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int IDX_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [VEC_W-1:0]          rd_vec,
  output logic [IDX_W-1:0]          cur_index,
  output logic                      f32_mode,
  output logic                      drop_err,
  output logic [BOOL_W-1:0]         bool_uni,
  output logic [NUM_INT*WORD_W-1:0] int_uni
);
  localparam int ALIAS_LSB = $clog2(ALIAS_N);
  localparam int INT_LSB   = $clog2(NUM_INT);

  wr_dec_t                 dec;
  logic [INT_LSB-1:0]      int_n;
  logic [BOOL_W-1:0]       bool_q;
  logic [WORD_W-1:0]       int_q [NUM_INT];
  logic                    vec_valid;
  logic [VEC_W-1:0]        vec;

  always_comb begin
    dec.cfg   = wr_en && (wr_sel == SEL_CFG);
    dec.bools = wr_en && (wr_sel == SEL_BOOL);
    dec.ints  = wr_en && (wr_sel[SEL_W-1:INT_LSB] == SEL_INT[SEL_W-1:INT_LSB]);
    dec.data  = wr_en && (wr_sel[SEL_W-1:ALIAS_LSB] == SEL_DATA[SEL_W-1:ALIAS_LSB]);
    int_n     = wr_sel[INT_LSB-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bool_q <= '0;
    else if (dec.bools) bool_q <= wr_data[BOOL_W-1:0];
  end

  genvar n;
  generate
    for (n = 0; n < NUM_INT; n++) begin : g_int
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   int_q[n] <= '0;
        else if (dec.ints && (int_n == INT_LSB'(n)))  int_q[n] <= wr_data;
      end
      assign int_uni[n*WORD_W +: WORD_W] = int_q[n];
    end
  endgenerate

  uniform_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_we   (dec.data),
    .clear     (dec.cfg),
    .mode_f32  (f32_mode),
    .wdata     (wr_data),
    .vec_valid (vec_valid),
    .vec_o     (vec)
  );

  uniform_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (dec.cfg),
    .cfg_idx   (wr_data[IDX_W-1:0]),
    .cfg_mode  (wr_data[MODE_BIT]),
    .vec_valid (vec_valid),
    .vec_i     (vec),
    .rd_idx    (rd_idx),
    .rd_vec    (rd_vec),
    .idx_o     (cur_index),
    .mode_o    (f32_mode),
    .drop_o    (drop_err)
  );

  assign bool_uni = bool_q;

  p_bool_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec.bools |=> (bool_uni == $past(wr_data[BOOL_W-1:0])));
  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dec.cfg && !dec.bools && !dec.ints && !dec.data)
      |=> ($stable(cur_index) && $stable(bool_uni) && $stable(int_uni)));
endmodule

// File: tb/tb_uniform_pack_loader.sv
module tb_uniform_pack_loader;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [4:0]   wr_sel;
  logic [31:0]  wr_data;
  logic [6:0]   rd_idx;
  logic [95:0]  rd_vec;
  logic [6:0]   cur_index;
  logic         f32_mode;
  logic         drop_err;
  logic [15:0]  bool_uni;
  logic [127:0] int_uni;

  always #4 clk = ~clk;

  uniform_pack_loader dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_vec(rd_vec), .cur_index(cur_index), .f32_mode(f32_mode),
    .drop_err(drop_err), .bool_uni(bool_uni), .int_uni(int_uni)
  );

  int total = 0;
  int bad   = 0;

  logic [6:0]   m_idx;
  logic         m_mode;
  int           m_cnt;
  logic [31:0]  m_buf [3];
  logic [95:0]  m_mem [96];
  logic         m_drop;
  logic [15:0]  m_bool;
  logic [127:0] m_int;
  int           m_last;

  function automatic logic [23:0] cvt(input logic [31:0] f);
    logic [7:0] e;
    e = f[30:23];
    if (e <= 8'd64)  return {f[31], 23'd0};
    if (e >= 8'd192) return {f[31], 7'h7F, 16'd0};
    return {f[31], 7'(e - 8'd64), f[22:7]};
  endfunction

  function automatic logic [95:0] build(input logic md, input logic [31:0] a, b, c, d);
    if (md) return {cvt(a), cvt(b), cvt(c), cvt(d)};
    return {a[31:8], a[7:0], b[31:16], b[15:0], c[31:24], c[23:0]};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [4:0] s, input logic [31:0] d);
    int si;
    logic [95:0] v;
    si = int'(s);
    m_drop = 1'b0;
    m_last = -1;
    if (si == 0) begin
      m_idx = d[6:0]; m_mode = d[31]; m_cnt = 0;
    end else if (si == 1) begin
      m_bool = d[15:0];
    end else if (si >= 4 && si < 8) begin
      m_int[32*(si-4) +: 32] = d;
    end else if (si >= 8 && si < 16) begin
      if (m_cnt == (m_mode ? 3 : 2)) begin
        v = m_mode ? build(1'b1, m_buf[0], m_buf[1], m_buf[2], d)
                   : build(1'b0, m_buf[0], m_buf[1], d, 32'd0);
        m_cnt = 0;
        if (m_idx < 7'd96) begin
          m_mem[m_idx] = v; m_last = int'(m_idx); m_idx = m_idx + 7'd1;
        end else begin
          m_drop = 1'b1;
        end
      end else begin
        m_buf[m_cnt] = d; m_cnt++;
      end
    end
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model(s, d);
  endtask

  task automatic chk_vec(input string tag, input int i);
    rd_idx = 7'(i);
    #1;
    chk(tag, {32'd0, rd_vec}, {32'd0, (i < 96) ? m_mem[i] : 96'd0});
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " index R5"}, {121'd0, cur_index}, {121'd0, m_idx});
    chk({tag, " mode R7"},  {127'd0, f32_mode},  {127'd0, m_mode});
    chk({tag, " drop R6"},  {127'd0, drop_err},  {127'd0, m_drop});
    chk({tag, " bool R9"},  {112'd0, bool_uni},  {112'd0, m_bool});
    chk({tag, " int R10"},  int_uni,             m_int);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_idx = '0;
    m_idx = '0; m_mode = 1'b0; m_cnt = 0; m_drop = 1'b0; m_bool = '0; m_int = '0; m_last = -1;
    for (int i = 0; i < 96; i++) m_mem[i] = '0;
    for (int i = 0; i < 3; i++) m_buf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk_state("R11 reset");
    chk_vec("R11 reset entry0", 0);
    chk_vec("R11 reset entry95", 95);

    // R3, R8: packed vector via three different aliases
    wr(5'h00, 32'h0000_0005);
    wr(5'h08, 32'h1122_3344);
    wr(5'h0B, 32'h5566_7788);
    wr(5'h0F, 32'h99AA_BBCC);
    chk("R3 packed split", {32'd0, build(1'b0, 32'h11223344, 32'h55667788, 32'h99AABBCC, 0)},
        {32'd0, 96'h112233_445566_778899_AABBCC});
    chk_vec("R3 packed store", 5);
    chk_state("R5 after packed");

    // R1, R2, R4: float32 vector; nothing lands before the 4th word
    wr(5'h00, 32'h8000_000A);
    wr(5'h09, 32'h3F80_0000);
    wr(5'h0A, 32'hC000_0000);
    wr(5'h0C, 32'h0080_0000);
    chk_vec("R1 no early store", 10);
    chk_state("R1 index held");
    wr(5'h0D, 32'h7F00_0000);
    chk("R4 conv", {32'd0, m_mem[10]}, {32'd0, 96'h3F0000_C00000_000000_7F0000});
    chk_vec("R2 f32 reversed", 10);
    chk_state("R1 after f32");

    // R4: exponent thresholds
    wr(5'h0E, 32'h2080_0000);
    wr(5'h0E, 32'h2000_0000);
    wr(5'h0E, 32'h5F81_2345);
    wr(5'h0E, 32'hE000_0000);
    chk("R4 thresholds", {32'd0, m_mem[11]}, {32'd0, 96'h010000_000000_7F0246_FF0000});
    chk_vec("R4 threshold store", 11);

    // R7: setup write in mid-vector discards partial words
    wr(5'h00, 32'h0000_0014);
    wr(5'h08, 32'hDEAD_BEEF);
    wr(5'h08, 32'hCAFE_F00D);
    wr(5'h00, 32'h0000_0014);
    wr(5'h08, 32'h0102_0304);
    wr(5'h08, 32'h0506_0708);
    chk_vec("R7 partial cleared (not yet stored)", 20);
    wr(5'h08, 32'h090A_0B0C);
    chk("R7 restart", {32'd0, m_mem[20]}, {32'd0, 96'h010203_040506_070809_0A0B0C});
    chk_vec("R7 store", 20);

    // R6, R12: last slot, then drop
    wr(5'h00, 32'h0000_005F);
    for (int k = 0; k < 3; k++) wr(5'h08, 32'hA5A5_0000 + k);
    chk_vec("R6 last slot", 95);
    chk_state("R6 index at 96");
    for (int k = 0; k < 3; k++) wr(5'h08, 32'h1234_5678);
    chk_state("R6 drop pulse");
    chk_vec("R6 slot 95 kept", 95);
    @(negedge clk);
    m_drop = 1'b0;
    chk_state("R6 pulse ends");
    chk_vec("R12 out of range 96", 96);
    chk_vec("R12 out of range 127", 127);

    // R9, R10, R8: boolean, integer, unmapped
    wr(5'h01, 32'hABCD_1234);
    chk_state("R9 bool");
    for (int n = 0; n < 4; n++) wr(5'(4 + n), 32'h1000_0001 * (n + 1));
    chk_state("R10 int");
    wr(5'h00, 32'h0000_0030);
    wr(5'h02, 32'hFFFF_FFFF);
    wr(5'h03, 32'hFFFF_FFFF);
    wr(5'h13, 32'hFFFF_FFFF);
    wr(5'h1F, 32'hFFFF_FFFF);
    wr(5'h08, 32'h0);
    wr(5'h08, 32'h0);
    chk_state("R8 unmapped ignored");
    chk_vec("R8 unmapped no store", 48);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [4:0] s;
      logic [31:0] d;
      op = int'($urandom_range(0, 19));
      d  = $urandom;
      if (op == 0)      begin s = 5'h00; d[6:0] = 7'($urandom_range(0, 99)); end
      else if (op == 1) s = 5'h01;
      else if (op == 2) s = 5'(4 + $urandom_range(0, 3));
      else if (op == 3) s = 5'(16 + $urandom_range(0, 15));
      else              s = 5'(8 + $urandom_range(0, 7));
      wr(s, d);
      chk_state("R1 random");
      if (m_last >= 0) chk_vec("R2 R3 random store", m_last);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule